// File: doc/BRIEF.md
# Snooping Cache-Line Coherence Controller

This block keeps the coherence state of a single cache line and works out its next state under a snooping bus protocol. A parameter picks one of four protocol variants: MSI, MESI, MOSI or MOESI. A second parameter says whether the bus offers an upgrade transaction. If it does not, a write to a shared line must use a full read-exclusive.

The controller reacts to three kinds of event:

- a processor request: read, write, software prefetch or hardware prefetch;
- a bus response to a request the line issued, together with the shared-line indication;
- a command snooped from other agents on the bus.

For each event it reports the bus request to issue, whether this line must supply data, whether it must assert the shared line, and the state it will take. Any event the protocol does not define raises an error and leaves the state alone.

The lookup is combinational. The state register changes at the clock edge of an event. The variant must be 0 (MSI), 1 (MESI), 2 (MOSI) or 3 (MOESI). A variant with an Owned state must be built with upgrades enabled; any other setting stops elaboration.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: `line_state` is encoded as {valid, writable, dirty}: Invalid 000, Shared 100, Exclusive 110, Owned 101, Modified 111. Reset forces Invalid. Only the states of the configured variant ever appear: Exclusive only in MESI/MOESI, Owned only in MOSI/MOESI.
- R2: In Invalid, a processor read (`req_op` 0), software prefetch (2) or hardware prefetch (3) requests a bus read (`bus_req_op` 0). A processor write (1) requests a read-exclusive (`bus_req_op` 1).
- R3: A processor write in Shared, or in Owned, requests an upgrade (`bus_req_op` 2) when `UPGRADES` is 1 and a read-exclusive otherwise. A request never changes the state.
- R4: A read-exclusive response (`rsp_op` 1) in Invalid moves the line to Modified. In Shared or Owned, the completion of the write-to-shared request also moves it to Modified: an upgrade response (`rsp_op` 2) with upgrades enabled, or a read-exclusive response without them.
- R5: A read response (`rsp_op` 0) in Invalid moves the line to Exclusive in variants that have it and `rsp_shared` is low. In every other case it moves the line to Shared.
- R6: Snoops in Invalid and Shared (`snp_op` 0 read, 1 read-exclusive, 2 upgrade):
  - Invalid ignores a read and a read-exclusive, and also an upgrade when upgrades are enabled.
  - Shared raises `assert_shared` on a read only in Exclusive-capable variants.
  - Shared goes to Invalid on a read-exclusive, or on an upgrade when upgrades are enabled.
- R7: Exclusive raises `assert_shared` and stays put on a snooped read, and goes to Invalid on a snooped read-exclusive.
- R8: Modified supplies data on a snooped read-exclusive and goes to Invalid. On a snooped read it supplies data and goes to Owned if the variant has Owned, otherwise to Shared.
- R9: Owned supplies data and stays Owned on a snooped read. It supplies data and goes to Invalid on a snooped read-exclusive. It goes to Invalid without supplying on a snooped upgrade.
- R10: A snooped invalidate (`snp_op` 3) or write-invalidate (4) moves any state to Invalid, with no supply and no shared assertion.
- R11: Every other combination, including `rsp_op` 3 and `snp_op` 5 to 7, raises `err`. It also leaves the state unchanged and drives no bus request, supply or shared assertion.
- R12: A snoop outranks a response, and a response outranks a request, when strobes coincide. Only the winning event drives the outputs. With no strobe high, the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Processor request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 software prefetch, 3 hardware prefetch |
| rsp_vld | input | 1 | Bus response strobe |
| rsp_op | input | 2 | 0 read response, 1 read-exclusive response, 2 upgrade response |
| rsp_shared | input | 1 | Shared line sampled with the response |
| snp_vld | input | 1 | Snooped command strobe |
| snp_op | input | 3 | 0 read, 1 read-exclusive, 2 upgrade, 3 invalidate, 4 write-invalidate |
| bus_req_vld | output | 1 | A bus request must be issued |
| bus_req_op | output | 2 | 0 read, 1 read-exclusive, 2 upgrade |
| supply | output | 1 | This line supplies data for the snoop |
| assert_shared | output | 1 | Drive the shared line for the snoop |
| next_state | output | 3 | State after the current event |
| line_state | output | 3 | Registered coherence state |
| err | output | 1 | Event undefined in the current state |

## Verification
The assertions take it for granted that the state register is written only through the three strobes. They also assume that a snooped invalidate always arrives as a snoop and is never masked by a response or request in the same cycle.

The stimulus respects this. Every start state is reached only through legal responses and snoops from reset. Each variant and upgrade setting then gets every op code of every event kind from every reachable state. A few cycles drive coinciding strobes on purpose to exercise the priority order.

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl #(
  parameter int VARIANT  = 3,
  parameter bit UPGRADES = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_vld,
  input  logic [1:0] req_op,
  input  logic       rsp_vld,
  input  logic [1:0] rsp_op,
  input  logic       rsp_shared,
  input  logic       snp_vld,
  input  logic [2:0] snp_op,
  output logic       bus_req_vld,
  output logic [1:0] bus_req_op,
  output logic       supply,
  output logic       assert_shared,
  output logic [2:0] next_state,
  output logic [2:0] line_state,
  output logic       err
);

  localparam bit HAS_E  = (VARIANT == 1) || (VARIANT == 3);
  localparam bit HAS_O  = (VARIANT == 2) || (VARIANT == 3);
  localparam bit CFG_OK = (VARIANT >= 0) && (VARIANT <= 3) && (!HAS_O || UPGRADES);

  localparam logic [2:0] ST_I = 3'b000;
  localparam logic [2:0] ST_S = 3'b100;
  localparam logic [2:0] ST_E = 3'b110;
  localparam logic [2:0] ST_O = 3'b101;
  localparam logic [2:0] ST_M = 3'b111;

  localparam logic [1:0] BUS_RD  = 2'd0;
  localparam logic [1:0] BUS_RDX = 2'd1;
  localparam logic [1:0] BUS_UPG = 2'd2;

  localparam logic [1:0] Q_RD   = 2'd0;
  localparam logic [1:0] Q_WR   = 2'd1;

  localparam logic [1:0] P_RD   = 2'd0;
  localparam logic [1:0] P_RDX  = 2'd1;
  localparam logic [1:0] P_UPG  = 2'd2;

  localparam logic [2:0] N_RD   = 3'd0;
  localparam logic [2:0] N_RDX  = 3'd1;
  localparam logic [2:0] N_UPG  = 3'd2;
  localparam logic [2:0] N_INV  = 3'd3;
  localparam logic [2:0] N_WINV = 3'd4;

  localparam logic [1:0] WR_SHARED_BUS = UPGRADES ? BUS_UPG : BUS_RDX;
  localparam logic [1:0] WR_SHARED_RSP = UPGRADES ? P_UPG : P_RDX;

  if (!CFG_OK) begin : g_cfg_bad
    $error("snoop_coh_ctrl: unsupported variant or owned variant without upgrades");
  end

  logic [2:0] st;
  logic [2:0] nxt;
  logic       ok;
  logic       bv;
  logic [1:0] bo;
  logic       su;
  logic       as;
  logic       any_vld;
  logic       st_known;

  assign any_vld  = req_vld | rsp_vld | snp_vld;
  assign st_known = (st == ST_I) || (st == ST_S) || (st == ST_M) ||
                    (HAS_E && st == ST_E) || (HAS_O && st == ST_O);

  always_comb begin
    ok  = 1'b0;
    bv  = 1'b0;
    bo  = BUS_RD;
    su  = 1'b0;
    as  = 1'b0;
    nxt = st;
    if (snp_vld) begin
      if (snp_op == N_INV || snp_op == N_WINV) begin
        ok  = st_known;
        nxt = ST_I;
      end else begin
        case (st)
          ST_I: begin
            if (snp_op == N_RD || snp_op == N_RDX) ok = 1'b1;
            else if (snp_op == N_UPG && UPGRADES) ok = 1'b1;
          end
          ST_S: begin
            if (snp_op == N_RD) begin
              ok = 1'b1;
              as = HAS_E;
            end else if (snp_op == N_RDX || (snp_op == N_UPG && UPGRADES)) begin
              ok  = 1'b1;
              nxt = ST_I;
            end
          end
          ST_E: begin
            if (HAS_E && snp_op == N_RD) begin
              ok = 1'b1;
              as = 1'b1;
            end else if (HAS_E && snp_op == N_RDX) begin
              ok  = 1'b1;
              nxt = ST_I;
            end
          end
          ST_M: begin
            if (snp_op == N_RD) begin
              ok  = 1'b1;
              su  = 1'b1;
              nxt = HAS_O ? ST_O : ST_S;
            end else if (snp_op == N_RDX) begin
              ok  = 1'b1;
              su  = 1'b1;
              nxt = ST_I;
            end
          end
          ST_O: begin
            if (HAS_O && snp_op == N_RD) begin
              ok = 1'b1;
              su = 1'b1;
            end else if (HAS_O && snp_op == N_RDX) begin
              ok  = 1'b1;
              su  = 1'b1;
              nxt = ST_I;
            end else if (HAS_O && snp_op == N_UPG) begin
              ok  = 1'b1;
              nxt = ST_I;
            end
          end
          default: ok = 1'b0;
        endcase
      end
    end else if (rsp_vld) begin
      if (st == ST_I && rsp_op == P_RD) begin
        ok  = 1'b1;
        nxt = (HAS_E && !rsp_shared) ? ST_E : ST_S;
      end else if (st == ST_I && rsp_op == P_RDX) begin
        ok  = 1'b1;
        nxt = ST_M;
      end else if ((st == ST_S || (HAS_O && st == ST_O)) && rsp_op == WR_SHARED_RSP) begin
        ok  = 1'b1;
        nxt = ST_M;
      end
    end else if (req_vld) begin
      if (st == ST_I) begin
        ok = 1'b1;
        bv = 1'b1;
        bo = (req_op == Q_WR) ? BUS_RDX : BUS_RD;
      end else if ((st == ST_S || (HAS_O && st == ST_O)) && req_op == Q_WR) begin
        ok = 1'b1;
        bv = 1'b1;
        bo = WR_SHARED_BUS;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_I;
    else if (any_vld && ok) st <= nxt;
  end

  assign err           = any_vld & ~ok;
  assign bus_req_vld   = bv & ok;
  assign bus_req_op    = ok ? bo : BUS_RD;
  assign supply        = su & ok;
  assign assert_shared = as & ok;
  assign next_state    = (any_vld && ok) ? nxt : st;
  assign line_state    = st;

  logic unused_q;
  assign unused_q = ^{Q_RD};

endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk #(
  parameter int VARIANT  = 3,
  parameter bit UPGRADES = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_vld,
  input logic       rsp_vld,
  input logic       snp_vld,
  input logic [2:0] snp_op,
  input logic       bus_req_vld,
  input logic       supply,
  input logic       assert_shared,
  input logic [2:0] line_state,
  input logic       err
);

  localparam bit HAS_E = (VARIANT == 1) || (VARIANT == 3);
  localparam bit HAS_O = (VARIANT == 2) || (VARIANT == 3);

  logic unused_up;
  assign unused_up = UPGRADES;

  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'b000 || line_state == 3'b100 || line_state == 3'b111 ||
     (HAS_E && line_state == 3'b110) || (HAS_O && line_state == 3'b101)));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(line_state));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld || rsp_vld || snp_vld) |=> $stable(line_state));

  // R12
  busreq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_vld |-> (!snp_vld && !rsp_vld));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !rsp_vld && !snp_vld) |=> $stable(line_state));

  // R10
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_vld && (snp_op == 3'd3 || snp_op == 3'd4)) |=> line_state == 3'b000);

  // R8
  supply_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply |-> (snp_vld && line_state[0]));

  // R6
  shared_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    assert_shared |-> (snp_vld && line_state[2] && !line_state[0]));

endmodule

bind snoop_coh_ctrl coh_ctrl_chk #(.VARIANT(VARIANT), .UPGRADES(UPGRADES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .rsp_vld(rsp_vld),
  .snp_vld(snp_vld), .snp_op(snp_op), .bus_req_vld(bus_req_vld),
  .supply(supply), .assert_shared(assert_shared),
  .line_state(line_state), .err(err)
);

// File: tb/test_snoop_coh_ctrl.sv
`timescale 1ns/1ps
module test_snoop_coh_ctrl;

  localparam int NCFG = 6;

  function automatic int cfg_var(int k);
    return (k < 4) ? k : k - 4;
  endfunction

  function automatic bit cfg_up(int k);
    return k < 4;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       req_vld [NCFG];
  logic [1:0] req_op  [NCFG];
  logic       rsp_vld [NCFG];
  logic [1:0] rsp_op  [NCFG];
  logic       rsp_sh  [NCFG];
  logic       snp_vld [NCFG];
  logic [2:0] snp_op  [NCFG];
  logic       o_bv    [NCFG];
  logic [1:0] o_bo    [NCFG];
  logic       o_su    [NCFG];
  logic       o_as    [NCFG];
  logic [2:0] o_nx    [NCFG];
  logic [2:0] o_st    [NCFG];
  logic       o_err   [NCFG];

  for (genvar g = 0; g < NCFG; g++) begin : g_dut
    snoop_coh_ctrl #(.VARIANT(cfg_var(g)), .UPGRADES(cfg_up(g))) i_snoop_coh_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_vld(req_vld[g]), .req_op(req_op[g]),
      .rsp_vld(rsp_vld[g]), .rsp_op(rsp_op[g]), .rsp_shared(rsp_sh[g]),
      .snp_vld(snp_vld[g]), .snp_op(snp_op[g]),
      .bus_req_vld(o_bv[g]), .bus_req_op(o_bo[g]), .supply(o_su[g]),
      .assert_shared(o_as[g]), .next_state(o_nx[g]), .line_state(o_st[g]),
      .err(o_err[g])
    );
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] mst;

  // expected {err, bus_vld, bus_op[1:0], supply, shared, next[2:0]}
  // kind: 0 request, 1 response, 2 snoop
  function automatic logic [8:0] model(int v, bit up, logic [2:0] s, int kind, int op, bit sh);
    bit he = (v == 1) || (v == 3);
    bit ho = (v >= 2);
    bit ok = 0, bv = 0, su = 0, as = 0;
    logic [1:0] bo = 2'd0;
    logic [2:0] n = s;
    if (kind == 2) begin
      if (op == 3 || op == 4) begin ok = 1; n = 3'b000; end
      else if (s == 3'b000) ok = (op == 0) || (op == 1) || (op == 2 && up);   // R6
      else if (s == 3'b100) begin                                               // R6
        if (op == 0) begin ok = 1; as = he; end
        else if (op == 1 || (op == 2 && up)) begin ok = 1; n = 3'b000; end
      end else if (s == 3'b110) begin                                           // R7
        if (op == 0) begin ok = 1; as = 1; end
        else if (op == 1) begin ok = 1; n = 3'b000; end
      end else if (s == 3'b111) begin                                           // R8
        if (op == 0) begin ok = 1; su = 1; n = ho ? 3'b101 : 3'b100; end
        else if (op == 1) begin ok = 1; su = 1; n = 3'b000; end
      end else if (s == 3'b101) begin                                           // R9
        if (op == 0) begin ok = 1; su = 1; end
        else if (op == 1) begin ok = 1; su = 1; n = 3'b000; end
        else if (op == 2) begin ok = 1; n = 3'b000; end
      end
    end else if (kind == 1) begin
      if (s == 3'b000 && op == 0) begin ok = 1; n = (he && !sh) ? 3'b110 : 3'b100; end
      else if (s == 3'b000 && op == 1) begin ok = 1; n = 3'b111; end
      else if ((s == 3'b100 || s == 3'b101) && ((up && op == 2) || (!up && op == 1))) begin
        ok = 1; n = 3'b111;
      end
    end else begin
      if (s == 3'b000) begin ok = 1; bv = 1; bo = (op == 1) ? 2'd1 : 2'd0; end
      else if ((s == 3'b100 || s == 3'b101) && op == 1) begin ok = 1; bv = 1; bo = up ? 2'd2 : 2'd1; end
    end
    if (!ok) return {1'b1, 1'b0, 2'd0, 1'b0, 1'b0, s};
    return {1'b0, bv, bo, su, as, n};
  endfunction

  function automatic string tag_of(logic [2:0] s, int kind, int op, bit e);
    if (e) return "R11";
    if (kind == 2) begin
      if (op >= 3) return "R10";
      if (s == 3'b110) return "R7";
      if (s == 3'b111) return "R8";
      if (s == 3'b101) return "R9";
      return "R6";
    end
    if (kind == 1) return (op == 0) ? "R5" : "R4";
    return (s == 3'b000) ? "R2" : "R3";
  endfunction

  task automatic chk(string tag, int k, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cfg=%0d actual=%b expected=%b", tag, k, act, exp);
    end
  endtask

  task automatic clear(int k);
    req_vld[k] = 0; rsp_vld[k] = 0; snp_vld[k] = 0;
    req_op[k] = 0; rsp_op[k] = 0; rsp_sh[k] = 0; snp_op[k] = 0;
  endtask

  task automatic do_reset(int k);
    @(negedge clk);
    clear(k);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    mst = 3'b000;
    // R1
    chk("R1", k, {o_err[k], o_bv[k], o_bo[k], o_su[k], o_as[k], o_st[k]}, 9'd0);
  endtask

  // drive any mix of strobes; expected follows snoop > response > request
  task automatic drive(int k, bit qv, int qo, bit rv, int ro, bit sh, bit sv, int so, string force_tag);
    logic [8:0] e;
    int kind;
    int op;
    string t;
    @(negedge clk);
    req_vld[k] = qv; req_op[k] = 2'(qo);
    rsp_vld[k] = rv; rsp_op[k] = 2'(ro); rsp_sh[k] = sh;
    snp_vld[k] = sv; snp_op[k] = 3'(so);
    kind = sv ? 2 : (rv ? 1 : (qv ? 0 : 3));
    op   = sv ? so : (rv ? ro : qo);
    if (kind == 3) e = {1'b0, 1'b0, 2'd0, 1'b0, 1'b0, mst};
    else e = model(cfg_var(k), cfg_up(k), mst, kind, op, sh);
    t = (force_tag != "") ? force_tag : (kind == 3 ? "R12" : tag_of(mst, kind, op, e[8]));
    #2;
    chk(t, k, {o_err[k], o_bv[k], o_bo[k], o_su[k], o_as[k], o_nx[k]}, e);
    @(negedge clk);
    clear(k);
    mst = e[2:0];
    chk({t, "/R1"}, k, {6'd0, o_st[k]}, {6'd0, mst});
  endtask

  task automatic reach(int k, logic [2:0] s);
    do_reset(k);
    case (s)
      3'b100: drive(k, 0, 0, 1, 0, 1, 0, 0, "");
      3'b110: drive(k, 0, 0, 1, 0, 0, 0, 0, "");
      3'b111: drive(k, 0, 0, 1, 1, 0, 0, 0, "");
      3'b101: begin
        drive(k, 0, 0, 1, 1, 0, 0, 0, "");
        drive(k, 0, 0, 0, 0, 0, 1, 0, "");
      end
      default: ;
    endcase
  endtask

  initial begin
    for (int k = 0; k < NCFG; k++) clear(k);
    for (int k = 0; k < NCFG; k++) begin
      logic [2:0] sts [5];
      sts[0] = 3'b000; sts[1] = 3'b100; sts[2] = 3'b110; sts[3] = 3'b111; sts[4] = 3'b101;
      for (int si = 0; si < 5; si++) begin
        bit he = (cfg_var(k) == 1) || (cfg_var(k) == 3);
        bit ho = (cfg_var(k) >= 2);
        if (si == 2 && !he) continue;
        if (si == 4 && !ho) continue;
        for (int q = 0; q < 4; q++) begin
          reach(k, sts[si]);
          drive(k, 1, q, 0, 0, 0, 0, 0, "");
        end
        for (int r = 0; r < 8; r++) begin
          reach(k, sts[si]);
          drive(k, 0, 0, 1, r >> 1, r[0], 0, 0, "");
        end
        for (int n = 0; n < 8; n++) begin
          reach(k, sts[si]);
          drive(k, 0, 0, 0, 0, 0, 1, n, "");
        end
      end
      // R12: all three strobes from Modified, snoop wins
      reach(k, 3'b111);
      drive(k, 1, 1, 1, 1, 0, 1, 0, "R12");
      // R12: response beats request in Invalid
      reach(k, 3'b000);
      drive(k, 1, 1, 1, 0, 1, 0, 0, "R12");
      // R12: idle cycle holds state
      drive(k, 0, 0, 0, 0, 0, 0, 0, "R12");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule